// File: doc/BRIEF.md
# Five-Lane 7:1 Serializing Transmitter

This block turns a 35-bit parallel word, presented once per pixel clock, into five serial data streams. Each stream runs at seven times the pixel rate. The word is split into five 7-bit lanes. All five lanes load together at the start of every 7-bit frame and shift out most significant bit first. A sixth serial lane repeats a fixed 7-bit marker in step with the data frames, so a receiver can find each frame boundary from that lane's transitions. In video use the word holds 10 bits each of red, green and blue plus 5 control bits. The block does not depend on how the word is divided.

The pixel clock and the 7x bit clock come from outside and must be phase-aligned: every rising pixel edge coincides with a rising bit edge. A run-time select input chooses whether the word is sampled on the rising or the falling pixel edge. The sampled word then passes through a holding register that is clocked on the rising pixel edge. An active-low sleep input has two effects. It drops every output enable and clears all internal state at once. After it is released, the lanes carry all-zero frames until the first sampled word reaches them.

Top module: `px7_serial_tx`

## Requirements
- R1: Lane i (i = 0..4) serializes input bits din[7i+6:7i] on dout[i], and one deserialized frame from each lane rebuilds the whole 35-bit word.
- R2: Within a frame each lane sends bit 6 of its 7-bit field first and bit 0 last.
- R3: Exactly one frame of 7 bit-clock cycles goes out per pixel clock cycle, and the words come out in the order they were sampled, none dropped or repeated.
- R4: The marker lane sends 1100011 (leftmost bit first) in every frame, and its frame starts on the same bit-clock edge as the data lanes' frames.
- R5: With edge_rise high, the word is sampled on the rising pixel-clock edge, and values present only around the falling edge have no effect.
- R6: With edge_rise low, the word is sampled on the falling pixel-clock edge, and values present only around the rising edge have no effect.
- R7: While sleep_n is low, every output enable is low and every serial output is 0, taking effect without waiting for a clock; while sleep_n is high, all enables are high.
- R8: After sleep_n rises, the data lanes send all-zero frames until the first sampled word has passed through the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_px | input | 1 | Pixel clock, one word per cycle |
| clk_bit | input | 1 | Bit clock at 7x the pixel rate, rising edges aligned to clk_px rising edges |
| edge_rise | input | 1 | 1: sample on rising pixel edge; 0: sample on falling pixel edge |
| sleep_n | input | 1 | Active-low power-down; low clears state and disables outputs |
| din | input | 35 | Parallel word, lane i in bits [7i+6:7i] |
| dout | output | 5 | Serial data, one bit per lane |
| dout_oe | output | 5 | Output enable per data lane |
| mark_out | output | 1 | Serial frame-marker lane |
| mark_oe | output | 1 | Output enable for the marker lane |

## Verification
The assertions rely on the two clocks keeping their fixed 1:7 phase relationship. This lets a load strobe from the bit counter sample the holding register at a point where it is either stable or just being overwritten at the same edge. The stimulus derives both clocks from one time base, with rising edges that coincide. The assertions also assume that sleep_n changes away from bit-clock edges. The bench changes sleep_n only after a falling bit-clock edge and changes edge_rise only while the block is asleep. Each word is held across its chosen capture edge, and a decoy value is placed across the opposite pixel edge.

// File: rtl/px7_pkg.sv
package px7_pkg;

   typedef enum logic [1:0] {
      EDGE_RUNTIME   = 2'd0,
      EDGE_RISE_ONLY = 2'd1,
      EDGE_FALL_ONLY = 2'd2
   } edge_mode_e;

   function automatic int unsigned cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/px7_capture.sv
module px7_capture
   import px7_pkg::*;
#(
   parameter int unsigned WORD_W = 35,
   parameter edge_mode_e  MODE   = EDGE_RUNTIME
) (
   input  logic              clk_px,
   input  logic              rst_n,
   input  logic              edge_rise,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] hold
);

   logic [WORD_W-1:0] cap_sel;

   if (MODE == EDGE_RUNTIME) begin : g_both
      logic [WORD_W-1:0] rise_q;
      logic [WORD_W-1:0] fall_q;

      always_ff @(posedge clk_px or negedge rst_n) begin
         if (!rst_n) rise_q <= '0;
         else        rise_q <= din;
      end

      always_ff @(negedge clk_px or negedge rst_n) begin
         if (!rst_n) fall_q <= '0;
         else        fall_q <= din;
      end

      assign cap_sel = edge_rise ? rise_q : fall_q;
   end else if (MODE == EDGE_RISE_ONLY) begin : g_rise
      logic [WORD_W-1:0] rise_q;
      logic              unused_edge;

      assign unused_edge = edge_rise;

      always_ff @(posedge clk_px or negedge rst_n) begin
         if (!rst_n) rise_q <= '0;
         else        rise_q <= din;
      end

      assign cap_sel = rise_q;
   end else begin : g_fall
      logic [WORD_W-1:0] fall_q;
      logic              unused_edge;

      assign unused_edge = edge_rise;

      always_ff @(negedge clk_px or negedge rst_n) begin
         if (!rst_n) fall_q <= '0;
         else        fall_q <= din;
      end

      assign cap_sel = fall_q;
   end

   // holding register: hands the word to the rising-edge pixel domain
   always_ff @(posedge clk_px or negedge rst_n) begin
      if (!rst_n) hold <= '0;
      else        hold <= cap_sel;
   end

endmodule

// File: rtl/px7_framer.sv
module px7_framer
   import px7_pkg::*;
#(
   parameter int unsigned LANE_W = 7
) (
   input  logic clk_bit,
   input  logic rst_n,
   output logic load
);

   localparam int unsigned CW   = cnt_w(LANE_W);
   localparam logic [CW-1:0] LAST = CW'(LANE_W - 1);

   logic [CW-1:0] bit_cnt;

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)               bit_cnt <= '0;
      else if (bit_cnt == LAST) bit_cnt <= '0;
      else                      bit_cnt <= bit_cnt + 1'b1;
   end

   // shifters load on the edge that wraps the counter
   assign load = (bit_cnt == LAST);

endmodule

// File: rtl/px7_lane.sv
module px7_lane #(
   parameter int unsigned LANE_W = 7
) (
   input  logic              clk_bit,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LANE_W-1:0] par,
   output logic              ser
);

   logic [LANE_W-1:0] shreg;

   always_ff @(posedge clk_bit or negedge rst_n) begin
      if (!rst_n)    shreg <= '0;
      else if (load) shreg <= par;
      else           shreg <= {shreg[LANE_W-2:0], 1'b0};
   end

   assign ser = shreg[LANE_W-1];

endmodule

// File: rtl/px7_serial_tx.sv
module px7_serial_tx
   import px7_pkg::*;
#(
   parameter int unsigned       LANES      = 5,
   parameter int unsigned       LANE_W     = 7,
   parameter logic [LANE_W-1:0] FRAME_MARK = 7'b1100011,
   parameter edge_mode_e        MODE       = EDGE_RUNTIME
) (
   input  logic                    clk_px,
   input  logic                    clk_bit,
   input  logic                    edge_rise,
   input  logic                    sleep_n,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES-1:0]        dout,
   output logic [LANES-1:0]        dout_oe,
   output logic                    mark_out,
   output logic                    mark_oe
);

   localparam int unsigned WORD_W = LANES * LANE_W;

   if (LANES < 1 || LANE_W < 3) begin : g_bad_size
      $error("px7_serial_tx: need LANES >= 1 and LANE_W >= 3");
   end
   if (FRAME_MARK[LANE_W-1] != 1'b1 || FRAME_MARK == '1) begin : g_bad_mark
      $error("px7_serial_tx: FRAME_MARK must start high and contain a low bit");
   end

   logic [WORD_W-1:0] hold_word;
   logic              frame_load;

   px7_capture #(.WORD_W(WORD_W), .MODE(MODE)) u_capture (
      .clk_px    (clk_px),
      .rst_n     (sleep_n),
      .edge_rise (edge_rise),
      .din       (din),
      .hold      (hold_word)
   );

   px7_framer #(.LANE_W(LANE_W)) u_framer (
      .clk_bit (clk_bit),
      .rst_n   (sleep_n),
      .load    (frame_load)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      px7_lane #(.LANE_W(LANE_W)) u_lane (
         .clk_bit (clk_bit),
         .rst_n   (sleep_n),
         .load    (frame_load),
         .par     (hold_word[i*LANE_W +: LANE_W]),
         .ser     (dout[i])
      );
   end

   px7_lane #(.LANE_W(LANE_W)) u_mark (
      .clk_bit (clk_bit),
      .rst_n   (sleep_n),
      .load    (frame_load),
      .par     (FRAME_MARK),
      .ser     (mark_out)
   );

   assign dout_oe = {LANES{sleep_n}};
   assign mark_oe = sleep_n;

endmodule

// File: rtl/px7_serial_tx_chk.sv
module px7_serial_tx_chk #(
   parameter int unsigned LANES  = 5,
   parameter int unsigned LANE_W = 7
) (
   input logic                    clk_bit,
   input logic                    sleep_n,
   input logic                    load,
   input logic [LANES*LANE_W-1:0] hold,
   input logic [LANES-1:0]        dout,
   input logic [LANES-1:0]        dout_oe,
   input logic                    mark_out,
   input logic                    mark_oe
);

   // R7: asleep means quiet, disabled outputs
   always @(posedge clk_bit) begin
      if (!sleep_n) begin
         p_quiet_r7: assert (dout == '0 && mark_out == 1'b0 && dout_oe == '0 && mark_oe == 1'b0)
            else $error("p_quiet_r7: outputs active during sleep");
      end
   end

   // R4: marker lane starts every frame high, on the data-lane load edge
   p_mark_head_r4: assert property (@(posedge clk_bit) disable iff (!sleep_n)
      load |=> mark_out);

   // R3: load strobes are never back to back
   p_load_gap_r3: assert property (@(posedge clk_bit) disable iff (!sleep_n)
      load |=> !load);

   for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
      // R2: first bit out is the field MSB, then the next bit down
      p_msb_first_r2: assert property (@(posedge clk_bit) disable iff (!sleep_n)
         load |=> dout[i] == $past(hold[i*LANE_W + LANE_W - 1]));
      p_next_bit_r2: assert property (@(posedge clk_bit) disable iff (!sleep_n)
         load |=> ##1 dout[i] == $past(hold[i*LANE_W + LANE_W - 2], 2));
   end

endmodule

bind px7_serial_tx px7_serial_tx_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk_bit  (clk_bit),
   .sleep_n  (sleep_n),
   .load     (frame_load),
   .hold     (hold_word),
   .dout     (dout),
   .dout_oe  (dout_oe),
   .mark_out (mark_out),
   .mark_oe  (mark_oe)
);

// File: tb/px7_serial_tx_test.sv
module px7_serial_tx_test;

   localparam int LANES = 5;
   localparam int LW    = 7;
   localparam int WW    = LANES * LW;
   localparam logic [LW-1:0] MARK = 7'b1100011;

   logic          clk_px = 1'b0;
   logic          clk_bit = 1'b0;
   logic          edge_rise = 1'b1;
   logic          sleep_n = 1'b0;
   logic [WW-1:0] din = '0;
   logic [LANES-1:0] dout, dout_oe;
   logic          mark_out, mark_oe;

   px7_serial_tx uut (
      .clk_px(clk_px), .clk_bit(clk_bit), .edge_rise(edge_rise), .sleep_n(sleep_n),
      .din(din), .dout(dout), .dout_oe(dout_oe), .mark_out(mark_out), .mark_oe(mark_oe)
   );

   always #4  clk_bit = ~clk_bit;   // 125 MHz bit clock
   always #28 clk_px  = ~clk_px;    // pixel clock, 1/7 of it, rising edges aligned

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string mode_req = "R5";

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard
   logic [WW-1:0] exp_q[$];

   logic [LW-1:0]            h_clk;
   logic [LANES-1:0][LW-1:0] h_dat;
   logic [WW-1:0]            frame;
   bit  synced, seen_mark;
   int  since_mark, zero_frames, n_frames;

   always @(negedge clk_bit) begin
      if (!sleep_n) begin
         h_clk = '0; h_dat = '0; synced = 0; seen_mark = 0;
         since_mark = 0; zero_frames = 0; n_frames = 0;
      end else begin
         h_clk = {h_clk[LW-2:0], mark_out};
         for (int l = 0; l < LANES; l++) h_dat[l] = {h_dat[l][LW-2:0], dout[l]};
         if (h_clk == MARK) begin
            seen_mark = 1; since_mark = 0; n_frames++;
            for (int l = 0; l < LANES; l++) frame[l*LW +: LW] = h_dat[l];
            if (!synced && frame == '0) begin
               zero_frames++;
            end else if (exp_q.size() > 0) begin
               synced = 1;
               // R1 R2 R3: lane mapping, MSB-first order, one word per frame in order
               check(frame == exp_q[0], {"R1 R2 R3 ", mode_req, " frame"}, 64'(frame), 64'(exp_q[0]));
               void'(exp_q.pop_front());
            end
         end else begin
            since_mark++;
            if (seen_mark && since_mark == LW)
               check(1'b0, "R4 marker missing", 64'(h_clk), 64'(MARK));
         end
      end
   end

   task automatic drive(input bit rise_mode, input logic [WW-1:0] w);
      logic [WW-1:0] junk;
      junk = {$urandom, $urandom};
      junk[WW-1] = 1'b1;
      if (rise_mode) begin
         @(negedge clk_px); #14 din = w; exp_q.push_back(w);
         @(posedge clk_px); #14 din = junk;   // decoy across the falling edge (R5)
      end else begin
         @(posedge clk_px); #14 din = w; exp_q.push_back(w);
         @(negedge clk_px); #14 din = junk;   // decoy across the rising edge (R6)
      end
   endtask

   task automatic run_phase(input bit rise_mode, input int nwords);
      logic [WW-1:0] w;
      edge_rise = rise_mode;
      mode_req = rise_mode ? "R5" : "R6";
      din = '0;
      @(negedge clk_bit); sleep_n = 1'b1;
      #1;
      check(dout_oe == '1 && mark_oe, "R7 enables on", 64'({mark_oe, dout_oe}), 64'h3f);
      repeat (3) @(posedge clk_px);
      for (int k = 0; k < nwords; k++) begin
         case (k)
            0: w = '1;
            1: w = {5{7'b1000000}};
            2: w = {5{7'b0000001}};
            3: w = 35'h2AAAAAAAA;
            4: w = 35'h0000000FF;
            default: begin w = {$urandom, $urandom}; if (w == '0) w = 1; end
         endcase
         drive(rise_mode, w);
      end
      repeat (10) @(posedge clk_px);
      #2;
      check(exp_q.size() == 0, {"R3 ", mode_req, " words left"}, 64'(exp_q.size()), 64'd0);
      check(zero_frames > 0, "R8 zero frames after wake", 64'(zero_frames), 64'd1);
      check(n_frames >= nwords + 3, "R4 marker frames", 64'(n_frames), 64'(nwords + 3));
      exp_q.delete();
      // mid-stream power-down away from an edge: immediate quiet outputs
      @(posedge clk_bit); #3 sleep_n = 1'b0;
      #1;
      check(dout_oe == '0 && mark_oe == 1'b0, "R7 enables off", 64'({mark_oe, dout_oe}), 64'd0);
      check(dout == '0 && mark_out == 1'b0, "R7 outputs zero", 64'({mark_out, dout}), 64'd0);
      repeat (2) @(posedge clk_px);
   endtask

   initial begin
      #10;
      check(dout_oe == '0 && mark_oe == 1'b0, "R7 reset enables", 64'({mark_oe, dout_oe}), 64'd0);
      check(dout == '0 && mark_out == 1'b0, "R7 reset outputs", 64'({mark_out, dout}), 64'd0);
      run_phase(1'b1, 40);
      run_phase(1'b0, 40);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   int wd_cycles = 0;
   always @(posedge clk_bit) begin
      wd_cycles++;
      if (wd_cycles > 100000 && !done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd_cycles, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule